// File: doc/BRIEF.md
# Serial Auto-Baud Rate Detector

This block listens to an idle-high asynchronous receive line and works out how many clock cycles one bit lasts. The far end sends an ASCII space as a calibration character. Serial data goes least significant bit first, so the start bit and the five low-order zero bits of that character form one unbroken low run of six bit periods. The block counts the clock cycles of that low run and divides by six, rounding to the nearest cycle. It presents the result as a bit period together with a strobe that is one clock wide.

Measurement only arms once the line has stayed high for a minimum idle time. A falling edge in the middle of a character is therefore never taken for a start bit. A low run outside a plausible window is rejected with an error pulse, and the last good period is kept. The upper limit is set below twelve periods of the slowest supported rate, so a run of twice the real length cannot pass. The run counter saturates instead of wrapping, so a very long run cannot alias into the window. After a result or an error, the block waits for a fresh idle stretch before it arms again.

Top module: `baud_sense`

## Requirements
- R1: While `rst` is high and after it falls, `period` is 0 and `period_vld` and `run_err` are low until a measurement completes.
- R2: A low run is measured only after `rxd` has been high for at least MIN_IDLE consecutive cycles. A low run that starts earlier produces neither `period_vld` nor `run_err`.
- R3: For a measured low run of L cycles with MIN_LOW <= L <= MAX_LOW, `period` becomes floor((L + 3) / 6). This is L/6 rounded to the nearest integer, with exact halves rounded up.
- R4: `period_vld` is high for exactly one clock per accepted measurement. `period` changes only in a cycle where `period_vld` is high.
- R5: A low run with L > MAX_LOW pulses `run_err` for one clock, raises no `period_vld`, and leaves `period` unchanged.
- R6: A low run with L < MIN_LOW pulses `run_err` for one clock, raises no `period_vld`, and leaves `period` unchanged.
- R7: After a result or an error, the block ignores the line until it sees another MIN_IDLE high cycles. A complete space character (0x20: start bit, bits 0..7 = 0,0,0,0,0,1,0,0, stop bit) yields exactly one result, taken from its six-period opening run.
- R8: The run counter saturates at 2^CNT_W - 1 and never wraps. A run longer than that is reported as too long (R5) and is not accepted as a short run.
- R9: `run_err` and `period_vld` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| period | output | CNT_W | Measured bit period in clock cycles |
| period_vld | output | 1 | One-clock strobe when `period` takes a new value |
| run_err | output | 1 | One-clock strobe when a low run is rejected |

## Verification
The checker watches the output strobes on every cycle. It confirms that each strobe lasts one clock, that the two strobes never coincide, and that `period` holds between strobes. It also confirms that the run counter never moves backward while a run is being measured, which is the saturation property. The arithmetic of the result, the rounding of halves, the acceptance window edges, the idle gating and the behaviour on a whole space character depend on the stimulus history. Only the bench's directed scenarios can show those, by driving chosen run lengths and comparing `period` with the value computed from the requirement.

// File: rtl/abd_pkg.sv
package abd_pkg;

    // Low bit periods in the calibration character's opening run
    // (start bit plus five zero data bits of an ASCII space).
    localparam int LOW_RUN_BITS = 6;

    // Added to the run length before division so the quotient rounds to nearest.
    localparam int ROUND_BIAS = LOW_RUN_BITS / 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for enough high cycles
        ST_ARMED = 2'd1,  // idle satisfied, waiting for start bit
        ST_MEAS  = 2'd2,  // counting the low run
        ST_DIV   = 2'd3   // dividing, line ignored
    } abd_state_e;

    typedef struct packed {
        logic start;      // launch division
        logic err;        // run rejected
    } abd_evt_t;

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= RESET_VAL;
                else     s_q <= d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] pipe_q;
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= {STAGES{RESET_VAL}};
                else     pipe_q <= {pipe_q[STAGES-2:0], d};
            end
            assign q = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/abd_ctrl.sv
module abd_ctrl
    import abd_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MIN_IDLE = 64,
    parameter int MIN_LOW  = 12,
    parameter int MAX_LOW  = 60000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_s,
    input  logic             div_done,
    output logic             div_start,
    output logic [CNT_W-1:0] run_len,
    output logic             run_err,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             measuring
);
    localparam int IDLE_W = $clog2(MIN_IDLE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIM_HI  = CNT_W'(MAX_LOW);
    localparam logic [CNT_W-1:0] LIM_LO  = CNT_W'(MIN_LOW);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(MIN_IDLE - 1);

    abd_state_e        state_q;
    logic [IDLE_W-1:0] idle_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  len_q;
    abd_evt_t          evt_q;
    logic              cnt_top;
    logic              out_of_win;

    assign cnt_top    = (cnt_q == CNT_MAX);
    assign out_of_win = (cnt_q > LIM_HI) || (cnt_q < LIM_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idle_q  <= '0;
            cnt_q   <= '0;
            len_q   <= '0;
            evt_q   <= '0;
        end else begin
            evt_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (!rx_s) begin
                        idle_q <= '0;
                    end else if (idle_q == IDLE_LAST) begin
                        idle_q  <= '0;
                        state_q <= ST_ARMED;
                    end else begin
                        idle_q <= idle_q + 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (!rx_s) begin
                        cnt_q   <= CNT_W'(1);
                        state_q <= ST_MEAS;
                    end
                end
                ST_MEAS: begin
                    if (!rx_s) begin
                        if (!cnt_top) cnt_q <= cnt_q + 1'b1;
                    end else begin
                        cnt_q <= '0;
                        if (out_of_win) begin
                            evt_q.err <= 1'b1;
                            state_q   <= ST_IDLE;
                        end else begin
                            len_q       <= cnt_q;
                            evt_q.start <= 1'b1;
                            state_q     <= ST_DIV;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign div_start = evt_q.start;
    assign run_err   = evt_q.err;
    assign run_len   = len_q;
    assign meas_cnt  = cnt_q;
    assign measuring = (state_q == ST_MEAS);
endmodule

// File: rtl/abd_div.sv
module abd_div #(
    parameter int NUM_W   = 17,
    parameter int OUT_W   = 16,
    parameter int DIVISOR = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    output logic             done,
    output logic [OUT_W-1:0] quot
);
    localparam int REM_W  = $clog2(DIVISOR) + 1;
    localparam int STEP_W = $clog2(NUM_W + 1);
    localparam logic [REM_W-1:0] DIV_V = REM_W'(DIVISOR);

    logic [NUM_W-1:0]  dvd_q;
    logic [OUT_W-1:0]  quo_q;
    logic [REM_W-1:0]  rem_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic              done_q;
    logic [REM_W-1:0]  rem_sh;
    logic              fits;
    logic [REM_W-1:0]  rem_nx;

    always_comb begin
        rem_sh = {rem_q[REM_W-2:0], dvd_q[NUM_W-1]};
        fits   = (rem_sh >= DIV_V);
        rem_nx = fits ? (rem_sh - DIV_V) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !run_q) begin
                dvd_q  <= num;
                quo_q  <= '0;
                rem_q  <= '0;
                step_q <= STEP_W'(NUM_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                dvd_q  <= dvd_q << 1;
                quo_q  <= {quo_q[OUT_W-2:0], fits};
                rem_q  <= rem_nx;
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quot = quo_q;
endmodule

// File: rtl/baud_sense.sv
module baud_sense
    import abd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_IDLE    = 64,
    parameter int MIN_LOW     = 12,
    parameter int MAX_LOW     = 60000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    output logic [CNT_W-1:0] period,
    output logic             period_vld,
    output logic             run_err
);
    localparam int NUM_W = CNT_W + 1;

    logic             rx_s;
    logic             div_start;
    logic             div_done;
    logic [CNT_W-1:0] run_len;
    logic [NUM_W-1:0] div_num;
    logic [CNT_W-1:0] div_quot;
    logic [CNT_W-1:0] meas_cnt;
    logic             measuring;
    logic [CNT_W-1:0] period_q;
    logic             vld_q;

    abd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rx_s)
    );

    abd_ctrl #(
        .CNT_W    (CNT_W),
        .MIN_IDLE (MIN_IDLE),
        .MIN_LOW  (MIN_LOW),
        .MAX_LOW  (MAX_LOW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rx_s      (rx_s),
        .div_done  (div_done),
        .div_start (div_start),
        .run_len   (run_len),
        .run_err   (run_err),
        .meas_cnt  (meas_cnt),
        .measuring (measuring)
    );

    assign div_num = {1'b0, run_len} + NUM_W'(ROUND_BIAS);

    abd_div #(.NUM_W(NUM_W), .OUT_W(CNT_W), .DIVISOR(LOW_RUN_BITS)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .done  (div_done),
        .quot  (div_quot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= div_done;
            if (div_done) period_q <= div_quot;
        end
    end

    assign period     = period_q;
    assign period_vld = vld_q;
endmodule

// File: rtl/baud_sense_chk.sv
module baud_sense_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] period,
    input logic             period_vld,
    input logic             run_err,
    input logic [CNT_W-1:0] meas_cnt,
    input logic             measuring
);
    AST_VLD_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        period_vld |=> !period_vld);  // R4

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
        !period_vld |-> (period == $past(period)));  // R4

    AST_ERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        run_err |=> !run_err);  // R5

    AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        run_err |-> (period == $past(period)));  // R6

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(run_err && period_vld));  // R9

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (measuring && $past(measuring)) |-> (meas_cnt >= $past(meas_cnt)));  // R8
endmodule

bind baud_sense baud_sense_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .period     (period),
    .period_vld (period_vld),
    .run_err    (run_err),
    .meas_cnt   (meas_cnt),
    .measuring  (measuring)
);

// File: tb/baud_sense_tb_top.sv
`timescale 1ns/1ps
module baud_sense_tb_top;
    localparam int CNT_W    = 12;
    localparam int MIN_IDLE = 40;
    localparam int MIN_LOW  = 12;
    localparam int MAX_LOW  = 2000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rxd = 1'b1;
    logic [CNT_W-1:0] period;
    logic             period_vld;
    logic             run_err;

    int checks = 0;
    int errors = 0;
    int vld_n  = 0;
    int err_n  = 0;
    int wide_n = 0;
    int both_n = 0;
    int last_per = 0;
    logic prev_vld = 1'b0;
    logic prev_err = 1'b0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    baud_sense #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (2),
        .MIN_IDLE    (MIN_IDLE),
        .MIN_LOW     (MIN_LOW),
        .MAX_LOW     (MAX_LOW)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .rxd        (rxd),
        .period     (period),
        .period_vld (period_vld),
        .run_err    (run_err)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (period_vld) begin
                vld_n++;
                last_per = int'(period);
            end
            if (run_err) err_n++;
            if ((period_vld && prev_vld) || (run_err && prev_err)) wide_n++;
            if (period_vld && run_err) both_n++;
            prev_vld = period_vld;
            prev_err = run_err;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic line(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // Accepted run: one result, no error, rounded quotient
    task automatic run_good(input int len, input string tag);
        int v0 = vld_n;
        int e0 = err_n;
        int exp_p = (len + 3) / 6;
        line(1'b1, 60);
        line(1'b0, len);
        line(1'b1, 60);
        check(vld_n == v0 + 1, {tag, " result count"}, vld_n - v0, 1);
        check(err_n == e0, {tag, " error count"}, err_n - e0, 0);
        check(int'(period) == exp_p, {tag, " period"}, int'(period), exp_p);
    endtask

    // Rejected run: one error, no result, period kept
    task automatic run_bad(input int len, input string tag);
        int v0 = vld_n;
        int e0 = err_n;
        int p0 = int'(period);
        line(1'b1, 60);
        line(1'b0, len);
        line(1'b1, 60);
        check(err_n == e0 + 1, {tag, " error count"}, err_n - e0, 1);
        check(vld_n == v0, {tag, " result count"}, vld_n - v0, 0);
        check(int'(period) == p0, {tag, " period kept"}, int'(period), p0);
    endtask

    task automatic t_reset();
        check(period == '0, "R1 period at reset", int'(period), 0);
        check(!period_vld, "R1 valid at reset", int'(period_vld), 0);
        check(!run_err, "R1 error at reset", int'(run_err), 0);
    endtask

    task automatic t_premature();
        int v0 = vld_n;
        int e0 = err_n;
        line(1'b1, 10);
        line(1'b0, 120);
        line(1'b1, 60);
        check(vld_n == v0, "R2 early edge result", vld_n - v0, 0);
        check(err_n == e0, "R2 early edge error", err_n - e0, 0);
        check(period == '0, "R2 early edge period", int'(period), 0);
    endtask

    task automatic t_rounding();
        run_good(120, "R3 exact 20");
        run_good(125, "R3 round up 125");
        run_good(122, "R3 round down 122");
        run_good(123, "R3 half up 123");
        run_good(42,  "R3 short 7");
    endtask

    task automatic t_limits();
        run_good(MAX_LOW, "R5 at max");
        run_bad(MAX_LOW + 1, "R5 above max");
        run_bad(MIN_LOW - 1, "R6 below min");
        run_good(MIN_LOW, "R6 at min");
    endtask

    task automatic t_saturate();
        // 5000 cycles wraps a 12-bit count to 904 unless it saturates
        run_bad(5000, "R8 saturating run");
    endtask

    task automatic t_space(input int bit_t);
        int v0 = vld_n;
        int e0 = err_n;
        logic [7:0] ch = 8'h20;
        line(1'b1, 60);
        line(1'b0, bit_t);                 // start bit
        for (int i = 0; i < 8; i++) line(ch[i], bit_t);
        line(1'b1, bit_t);                 // stop bit
        line(1'b1, 60);
        check(vld_n == v0 + 1, "R7 space result count", vld_n - v0, 1);
        check(err_n == e0, "R7 space error count", err_n - e0, 0);
        check(int'(period) == bit_t, "R7 space period", int'(period), bit_t);
    endtask

    task automatic t_rearm();
        int v0 = vld_n;
        int e0 = err_n;
        line(1'b1, 60);
        line(1'b0, 120);
        line(1'b1, 25);
        line(1'b0, 60);
        line(1'b1, 60);
        check(vld_n == v0 + 1, "R7 rearm result count", vld_n - v0, 1);
        check(err_n == e0, "R7 rearm error count", err_n - e0, 0);
        check(int'(period) == 20, "R7 rearm period", int'(period), 20);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_premature();
        t_rounding();
        t_limits();
        t_saturate();
        t_space(16);
        t_space(9);
        t_rearm();
        check(wide_n == 0, "R4 strobe width", wide_n, 0);
        check(both_n == 0, "R9 strobe overlap", both_n, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule